// File: doc/BRIEF.md
# Lane-wise Packed Dword Shuffle Unit

This block is a registered SIMD permute stage. It takes a 256-bit source vector and rearranges its 32-bit dwords under an 8-bit order control. The control is made of four 2-bit selectors. Each selector names one dword of the same 128-bit lane of the source, and that dword is written to one position of the result. Any source dword may be picked by several selectors.

The width of the operation and the handling of the upper half come from a 2-bit mode select:
- Keep mode shuffles the low lane and passes the upper half of the incoming destination value through unchanged.
- Clear mode shuffles the low lane and zeroes the upper half.
- Wide mode shuffles both lanes independently, with the same selectors in each lane.

A 4-bit specifier field must read all ones. Any other value in this field, or the reserved mode, turns the operation into a fault. A fault raises a registered fault flag in place of the valid flag and leaves the result register untouched.

The unit has exactly one cycle of latency. An operation presented with `inValid` high at a rising edge appears on the outputs after that edge. Decode, register access, operand fetch and exception delivery all sit outside this block.

Top module: `shuf_unit`

## Requirements
- R1: Result dword k of the low lane (k = 0..3) is taken from `orderCtl[2k+1:2k]`. A selector value of 0, 1, 2 or 3 picks source dword 0, 1, 2 or 3 of that lane.
- R2: One source dword may feed several result dwords in the same operation, up to all four of a lane (for example order 8'h00 or 8'hFF).
- R3: With `modeSel` = 2'b10 (wide), result dwords 4..7 take source dwords 4..7, chosen by the same four selectors as the low lane. No selection ever crosses the 128-bit lane boundary.
- R4: With `modeSel` = 2'b00 (keep), `resultVec[255:128]` equals `dstVec[255:128]` as sampled with the operation.
- R5: With `modeSel` = 2'b01 (clear), `resultVec[255:128]` is zero.
- R6: If `specField` is not 4'b1111 on an accepted operation, the next cycle shows `outFault` = 1 and `outValid` = 0.
- R7: If `modeSel` = 2'b11 on an accepted operation, the next cycle shows `outFault` = 1 and `outValid` = 0.
- R8: A faulting operation, or a cycle with `inValid` low, leaves `resultVec` holding its previous value.
- R9: `outValid` and `outFault` are registered with one cycle of latency after `inValid`. Both are low in the cycle after `inValid` is low, and they are never high together.
- R10: A synchronous active-high `rst` clears `outValid`, `outFault` and `resultVec` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation present this cycle |
| srcVec | input | 256 | Source vector, dword 0 in bits [31:0] |
| dstVec | input | 256 | Current destination value, used for the upper half in keep mode |
| orderCtl | input | 8 | Four 2-bit dword selectors |
| modeSel | input | 2 | 00 keep, 01 clear, 10 wide, 11 reserved (fault) |
| specField | input | 4 | Encoding check field, must be 4'b1111 |
| outValid | output | 1 | Result written this cycle |
| outFault | output | 1 | Operation rejected this cycle |
| resultVec | output | 256 | Registered shuffle result |

## Verification
The hardest case to reach is a result that is kept across a fault. The held value is only visible if a known result is already in the register, a faulting operation then arrives with different data, and a legal one follows without any idle gap. The stimulus therefore places faults from both causes, a bad specifier and the reserved mode, directly between legal operations that use distinct random data. The bench compares `resultVec` on every clock, so a stray write shows up at once. Back-to-back operations whose modes alternate between keep, clear and wide also expose any state of the upper half that leaks from one operation into the next.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int DWORD_W = 32;
  localparam int LANE_DW = 4;
  localparam int LANES   = 2;
  localparam int SPEC_W  = 4;
  localparam int SEL_W   = $clog2(LANE_DW);
  localparam int LANE_W  = DWORD_W * LANE_DW;
  localparam int VEC_W   = LANE_W * LANES;
  localparam int ORDER_W = SEL_W * LANE_DW;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WIDE  = 2'b10,
    MODE_BAD   = 2'b11
  } shuf_mode_e;

  typedef struct packed {
    logic       loadEn;
    shuf_mode_e laneMode;
  } shuf_ctrl_t;
endpackage

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
  import shuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        modeSel,
  input  logic [SPEC_W-1:0] specField,
  output shuf_ctrl_t        ctrlOut,
  output logic              outValid,
  output logic              outFault
);
  shuf_mode_e modeDec;
  logic       specOk;
  logic       modeOk;
  logic       opLegal;

  always_comb begin
    modeDec = shuf_mode_e'(modeSel);
    specOk  = (specField == {SPEC_W{1'b1}});
    modeOk  = (modeDec != MODE_BAD);
    opLegal = specOk && modeOk;
    ctrlOut.loadEn   = inValid && opLegal;
    ctrlOut.laneMode = modeDec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outFault <= 1'b0;
    end else begin
      outValid <= inValid && opLegal;
      outFault <= inValid && !opLegal;
    end
  end

  a_r6_spec_fault: assert property (@(posedge clk) disable iff (rst)
    (inValid && specField != {SPEC_W{1'b1}}) |=> (outFault && !outValid));
  a_r7_mode_fault: assert property (@(posedge clk) disable iff (rst)
    (inValid && modeSel == 2'b11) |=> (outFault && !outValid));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outFault));
  a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outFault));
  a_r9_valid_from_input: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));
endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import shuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  shuf_ctrl_t         ctrlIn,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [VEC_W-1:0]   dstVec,
  input  logic [ORDER_W-1:0] orderCtl,
  output logic [VEC_W-1:0]   resultVec
);
  localparam int UPPER_W = VEC_W - LANE_W;

  logic [DWORD_W-1:0] srcDw [LANES][LANE_DW];
  logic [VEC_W-1:0]   shuffled;
  logic [UPPER_W-1:0] upperNext;
  logic [VEC_W-1:0]   nextVec;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    for (genvar dw = 0; dw < LANE_DW; dw++) begin : g_dw
      assign srcDw[ln][dw] = srcVec[ln*LANE_W + dw*DWORD_W +: DWORD_W];
    end
    for (genvar dw = 0; dw < LANE_DW; dw++) begin : g_pick
      logic [SEL_W-1:0] pick;
      assign pick = orderCtl[dw*SEL_W +: SEL_W];
      assign shuffled[ln*LANE_W + dw*DWORD_W +: DWORD_W] = srcDw[ln][pick];
    end
  end

  always_comb begin
    unique case (ctrlIn.laneMode)
      MODE_KEEP:  upperNext = dstVec[VEC_W-1:LANE_W];
      MODE_CLEAR: upperNext = '0;
      MODE_WIDE:  upperNext = shuffled[VEC_W-1:LANE_W];
      default:    upperNext = resultVec[VEC_W-1:LANE_W];
    endcase
    nextVec = {upperNext, shuffled[LANE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)
      resultVec <= '0;
    else if (ctrlIn.loadEn)
      resultVec <= nextVec;
  end

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !ctrlIn.loadEn |=> $stable(resultVec));
  a_r5_clear_upper: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn.loadEn && ctrlIn.laneMode == MODE_CLEAR)
      |=> (resultVec[VEC_W-1:LANE_W] == '0));
  a_r4_keep_upper: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn.loadEn && ctrlIn.laneMode == MODE_KEEP)
      |=> (resultVec[VEC_W-1:LANE_W] == $past(dstVec[VEC_W-1:LANE_W])));
  a_r1_low_dword0: assert property (@(posedge clk) disable iff (rst)
    ctrlIn.loadEn |=> (resultVec[DWORD_W-1:0] ==
      $past(srcVec[orderCtl[SEL_W-1:0]*DWORD_W +: DWORD_W])));
endmodule

// File: rtl/shuf_unit.sv
module shuf_unit
  import shuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [VEC_W-1:0]   dstVec,
  input  logic [ORDER_W-1:0] orderCtl,
  input  logic [1:0]         modeSel,
  input  logic [SPEC_W-1:0]  specField,
  output logic               outValid,
  output logic               outFault,
  output logic [VEC_W-1:0]   resultVec
);
  shuf_ctrl_t ctrlBus;

  shuf_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .modeSel   (modeSel),
    .specField (specField),
    .ctrlOut   (ctrlBus),
    .outValid  (outValid),
    .outFault  (outFault)
  );

  shuf_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrlIn    (ctrlBus),
    .srcVec    (srcVec),
    .dstVec    (dstVec),
    .orderCtl  (orderCtl),
    .resultVec (resultVec)
  );
endmodule

// File: tb/shuf_unit_test.sv
`timescale 1ns/1ps
module shuf_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [255:0] srcVec = '0;
  logic [255:0] dstVec = '0;
  logic [7:0]   orderCtl = '0;
  logic [1:0]   modeSel = '0;
  logic [3:0]   specField = 4'hF;
  logic         outValid;
  logic         outFault;
  logic [255:0] resultVec;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic         expValid = 0;
  logic         expFault = 0;
  logic [255:0] expResult = '0;
  string        expTag = "R10";

  always #5 clk = ~clk;

  shuf_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVec(srcVec), .dstVec(dstVec),
    .orderCtl(orderCtl), .modeSel(modeSel), .specField(specField),
    .outValid(outValid), .outFault(outFault), .resultVec(resultVec)
  );

  function automatic logic [255:0] randVec();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural model of one lane: pick dwords by 2-bit selectors.
  function automatic logic [127:0] laneShuf(logic [127:0] lane, logic [7:0] ord);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      int s = (ord >> (2*k)) & 3;
      r[k*32 +: 32] = lane[s*32 +: 32];
    end
    return r;
  endfunction

  task automatic checkNow();
    testsRun++;
    if (outValid !== expValid || outFault !== expFault || resultVec !== expResult) begin
      testsFailed++;
      $display("FAIL %s: valid=%0b fault=%0b result=%h expected valid=%0b fault=%0b result=%h",
               expTag, outValid, outFault, resultVec, expValid, expFault, expResult);
    end
  endtask

  // Checks the outcome of the previous cycle, then applies a new one.
  task automatic step(string tag, logic v, logic [255:0] s, logic [255:0] d,
                      logic [7:0] o, logic [1:0] m, logic [3:0] sp);
    @(negedge clk);
    checkNow();
    inValid = v; srcVec = s; dstVec = d; orderCtl = o; modeSel = m; specField = sp;
    expTag = tag;
    if (!v) begin
      expValid = 0; expFault = 0;
    end else if (sp != 4'hF || m == 2'b11) begin
      expValid = 0; expFault = 1;
    end else begin
      expValid = 1; expFault = 0;
      expResult[127:0] = laneShuf(s[127:0], o);
      case (m)
        2'b00: expResult[255:128] = d[255:128];
        2'b01: expResult[255:128] = '0;
        default: expResult[255:128] = laneShuf(s[255:128], o);
      endcase
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [255:0] seq;
    for (int i = 0; i < 8; i++) seq[i*32 +: 32] = 32'h1000_0000 * (i + 1) + i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expTag = "R10";
    // R10: reset state
    step("R10", 0, '0, '0, 8'h00, 2'b00, 4'hF);
    // R1: identity and reversal, clear mode
    step("R1", 1, seq, randVec(), 8'hE4, 2'b01, 4'hF);
    step("R1", 1, seq, randVec(), 8'h1B, 2'b01, 4'hF);
    step("R1", 1, seq, randVec(), 8'h9C, 2'b00, 4'hF);
    // R2: broadcasts
    step("R2", 1, seq, randVec(), 8'h00, 2'b10, 4'hF);
    step("R2", 1, seq, randVec(), 8'hFF, 2'b10, 4'hF);
    step("R2", 1, seq, randVec(), 8'h55, 2'b01, 4'hF);
    // R3: wide mode, per-lane selection
    step("R3", 1, seq, randVec(), 8'hE4, 2'b10, 4'hF);
    step("R3", 1, seq, randVec(), 8'h4E, 2'b10, 4'hF);
    // R4 / R5: upper-half policy
    step("R4", 1, seq, randVec(), 8'h1B, 2'b00, 4'hF);
    step("R5", 1, randVec(), randVec(), 8'h1B, 2'b01, 4'hF);
    // R6 / R8: specifier fault between legal ops holds result
    step("R6", 1, randVec(), randVec(), 8'h27, 2'b10, 4'h7);
    step("R8", 1, randVec(), randVec(), 8'h27, 2'b10, 4'h0);
    step("R4", 1, randVec(), randVec(), 8'h8D, 2'b00, 4'hF);
    // R7 / R8: reserved mode
    step("R7", 1, randVec(), randVec(), 8'hE4, 2'b11, 4'hF);
    step("R8", 1, randVec(), randVec(), 8'hE4, 2'b11, 4'hE);
    // R9: idle cycles, values on the inputs ignored
    step("R9", 0, randVec(), randVec(), 8'hB1, 2'b10, 4'hF);
    step("R9", 0, randVec(), randVec(), 8'h00, 2'b01, 4'h3);
    step("R9", 1, randVec(), randVec(), 8'hB1, 2'b10, 4'hF);
    // Mixed random traffic over all modes and both fault causes
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m = 2'($urandom);
      logic [3:0] sp = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
      logic v = ($urandom % 6) != 0;
      string tg = !v ? "R9" : (sp != 4'hF) ? "R6" : (m == 2'b11) ? "R7" :
                  (m == 2'b00) ? "R4" : (m == 2'b01) ? "R5" : "R3";
      step(tg, v, randVec(), randVec(), 8'($urandom), m, sp);
    end
    step("R9", 0, '0, '0, 8'h00, 2'b00, 4'hF);
    // R10: reset mid-stream clears everything
    @(negedge clk);
    checkNow();
    rst = 1'b1;
    inValid = 1'b1; modeSel = 2'b10; specField = 4'hF; srcVec = randVec();
    expValid = 0; expFault = 0; expResult = '0; expTag = "R10";
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    checkNow();
    step("R10", 0, '0, '0, 8'h00, 2'b00, 4'hF);
    @(negedge clk);
    checkNow();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule